// File: doc/BRIEF.md
# Atomic Ordering Micro-op Expander

This block sits between the decoder and the memory pipeline. It takes one decoded memory instruction at a time, with an atomic marker and two ordering bits: acquire and release. It then emits the instruction as one to three micro-ops, one per output handshake. Each micro-op is either a memory operation or a fence. The acquire and release bits become explicit fences around the memory operation. A release places a fence before it, and an acquire places a fence after it.

The input and output both use valid/ready handshakes. While an instruction still has micro-ops to emit, the input is held off. The last micro-op of each instruction is flagged. A new instruction may be taken in the same cycle that this flagged micro-op is accepted, so back-to-back instructions flow without a bubble.

Top module: `amo_uop_expander`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: An atomic instruction with both ordering bits clear yields exactly one MEM micro-op (out_kind = 0), and that micro-op has out_last set.
- R3: An atomic instruction with only the acquire bit set yields MEM, then FENCE (out_kind = 1). Only the FENCE has out_last set.
- R4: An atomic instruction with only the release bit set yields FENCE, then MEM. Only the MEM has out_last set.
- R5: An atomic instruction with both bits set yields FENCE, MEM, FENCE. Only the final FENCE has out_last set.
- R6: The expansion depends only on the atomic marker and the two ordering bits, never on the op field. Swap, add, load-reserved and store-conditional encodings therefore expand identically.
- R7: A non-atomic instruction yields one MEM micro-op with out_last set, whatever its ordering bits are.
- R8: While out_valid is high and the current micro-op is not both last and accepted, in_ready is low.
- R9: While out_valid is high and out_ready is low, out_valid stays high and every out_* field holds its value into the next cycle.
- R10: A MEM micro-op carries op, address register and data exactly as received, with out_fence_mask all zeros. A FENCE micro-op carries out_fence_mask all ones and zero op, address register and data.
- R11: An accepted instruction presents its first micro-op in the next cycle. If it is accepted in the same cycle as the previous instruction's last micro-op, no idle cycle appears between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be taken |
| in_is_atomic | input | 1 | Instruction is an atomic (AMO, LR or SC) |
| in_aq | input | 1 | Acquire ordering bit |
| in_rl | input | 1 | Release ordering bit |
| in_op | input | OP_W | Operation code, passed through |
| in_addr_reg | input | REG_W | Address register index, passed through |
| in_data | input | DATA_W | Data operand, passed through |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_kind | output | 1 | 0 = MEM, 1 = FENCE |
| out_op | output | OP_W | Operation code (MEM only) |
| out_addr_reg | output | REG_W | Address register index (MEM only) |
| out_data | output | DATA_W | Data operand (MEM only) |
| out_fence_mask | output | MASK_W | Ordering mask, all ones on FENCE |
| out_last | output | 1 | Final micro-op of the instruction |

## Verification
The sequencing state is small, and a wrong phase shows up at the ports within one accepted handshake. Three symptoms are possible: a fence in the wrong slot, a missing fence, or out_last on the wrong micro-op. A stuck busy flag shows as in_ready low one cycle after the last micro-op. A dropped busy flag shows as in_ready rising while a fence is still owed. Stall cycles are checked for held outputs, because a phase that advances without a handshake loses a micro-op silently.

// File: rtl/amo_uop_expander.sv
module amo_uop_expander #(
  parameter int OP_W   = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 64,
  parameter int MASK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_atomic,
  input  logic              in_aq,
  input  logic              in_rl,
  input  logic [OP_W-1:0]   in_op,
  input  logic [REG_W-1:0]  in_addr_reg,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_kind,
  output logic [OP_W-1:0]   out_op,
  output logic [REG_W-1:0]  out_addr_reg,
  output logic [DATA_W-1:0] out_data,
  output logic [MASK_W-1:0] out_fence_mask,
  output logic              out_last
);

  typedef enum logic [1:0] {PH_PRE, PH_MEM, PH_POST} phase_t;

  phase_t              phase;
  logic                busy;
  logic                need_post;
  logic [OP_W-1:0]     op_q;
  logic [REG_W-1:0]    reg_q;
  logic [DATA_W-1:0]   data_q;

  logic is_mem, in_fire, out_fire;

  assign is_mem    = (phase == PH_MEM);
  assign out_valid = busy;
  assign out_last  = busy && ((phase == PH_POST) || (is_mem && !need_post));
  assign in_ready  = !busy || (out_ready && out_last);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;

  assign out_kind       = !is_mem;
  assign out_op         = is_mem ? op_q   : '0;
  assign out_addr_reg   = is_mem ? reg_q  : '0;
  assign out_data       = is_mem ? data_q : '0;
  assign out_fence_mask = is_mem ? '0     : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      phase     <= PH_MEM;
      need_post <= 1'b0;
      op_q      <= '0;
      reg_q     <= '0;
      data_q    <= '0;
    end else if (in_fire) begin
      busy      <= 1'b1;
      phase     <= (in_is_atomic && in_rl) ? PH_PRE : PH_MEM;
      need_post <= in_is_atomic && in_aq;
      op_q      <= in_op;
      reg_q     <= in_addr_reg;
      data_q    <= in_data;
    end else if (out_fire) begin
      if (out_last)             busy  <= 1'b0;
      else if (phase == PH_PRE) phase <= PH_MEM;
      else                      phase <= PH_POST;
    end
  end

  p_ready_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !(out_ready && out_last) |-> !in_ready);

  p_stall_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_op)
      && $stable(out_addr_reg) && $stable(out_data) && $stable(out_last));

  p_pre_fence_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_kind && !out_last |=> out_valid && !out_kind);

  p_post_fence_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && !out_kind && !out_last |=> out_valid && out_kind && out_last);

  p_fence_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_kind ? (out_fence_mask == '1 && out_data == '0)
                            : (out_fence_mask == '0)));

  p_plain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_is_atomic |=> out_valid && !out_kind && out_last);

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

endmodule

// File: tb/test_amo_uop_expander.sv
module test_amo_uop_expander;
  localparam int OP_W = 5, REG_W = 5, DATA_W = 64, MASK_W = 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_is_atomic = 0, in_aq = 0, in_rl = 0, out_ready = 0;
  logic [OP_W-1:0] in_op = '0;
  logic [REG_W-1:0] in_addr_reg = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, out_valid, out_kind, out_last;
  logic [OP_W-1:0] out_op;
  logic [REG_W-1:0] out_addr_reg;
  logic [DATA_W-1:0] out_data;
  logic [MASK_W-1:0] out_fence_mask;

  int checks = 0, errors = 0;
  bit done = 0;

  int n_got;
  logic g_kind [4];
  logic g_last [4];
  logic [OP_W-1:0] g_op [4];
  logic [REG_W-1:0] g_reg [4];
  logic [DATA_W-1:0] g_data [4];
  logic [MASK_W-1:0] g_mask [4];

  always #4 clk = ~clk;

  amo_uop_expander #(.OP_W(OP_W), .REG_W(REG_W), .DATA_W(DATA_W), .MASK_W(MASK_W)) i_amo_uop_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_atomic(in_is_atomic), .in_aq(in_aq), .in_rl(in_rl), .in_op(in_op),
    .in_addr_reg(in_addr_reg), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_kind(out_kind), .out_op(out_op),
    .out_addr_reg(out_addr_reg), .out_data(out_data),
    .out_fence_mask(out_fence_mask), .out_last(out_last));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic present(input logic a, input logic aq, input logic rl,
                         input logic [OP_W-1:0] op, input logic [REG_W-1:0] rg,
                         input logic [DATA_W-1:0] d);
    in_valid = 1; in_is_atomic = a; in_aq = aq; in_rl = rl;
    in_op = op; in_addr_reg = rg; in_data = d;
  endtask

  task automatic issue(input logic a, input logic aq, input logic rl,
                       input logic [OP_W-1:0] op, input logic [REG_W-1:0] rg,
                       input logic [DATA_W-1:0] d);
    @(negedge clk);
    out_ready = 0;
    present(a, aq, rl, op, rg, d);
    @(posedge clk);
  endtask

  task automatic collect(input int stall);
    n_got = 0;
    for (int cyc = 0; cyc < 20; cyc++) begin
      @(negedge clk);
      in_valid = 0;
      out_ready = (cyc >= stall);
      #1;
      if (out_valid && out_ready && n_got < 4) begin
        if (!out_last) chk("R8 in_ready low before last", in_ready, 0);
        g_kind[n_got] = out_kind; g_last[n_got] = out_last; g_op[n_got] = out_op;
        g_reg[n_got] = out_addr_reg; g_data[n_got] = out_data; g_mask[n_got] = out_fence_mask;
        n_got++;
        if (out_last) begin
          @(posedge clk);
          break;
        end
      end
      @(posedge clk);
    end
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic expect_seq(input string tag, input int n, input logic [2:0] kinds,
                            input logic [OP_W-1:0] op, input logic [REG_W-1:0] rg,
                            input logic [DATA_W-1:0] d);
    chk({tag, " count"}, n_got, n);
    for (int i = 0; i < n && i < n_got; i++) begin
      chk({tag, " kind"}, g_kind[i], kinds[i]);
      chk({tag, " last"}, g_last[i], i == n - 1);
      if (kinds[i]) begin
        chk("R10 fence mask", g_mask[i], {MASK_W{1'b1}});
        chk("R10 fence data", g_data[i], 0);
      end else begin
        chk("R10 mem op", g_op[i], op);
        chk("R10 mem reg", g_reg[i], rg);
        chk("R10 mem data", g_data[i], d);
        chk("R10 mem mask", g_mask[i], 0);
      end
    end
  endtask

  task automatic t_reset;
    #1;
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_plain;
    issue(1, 0, 0, 5'h01, 5'd3, 64'h1111_2222_3333_4444);
    collect(0);
    expect_seq("R2 plain", 1, 3'b000, 5'h01, 5'd3, 64'h1111_2222_3333_4444);
  endtask

  task automatic t_aq;
    issue(1, 1, 0, 5'h02, 5'd7, 64'hA5A5);
    collect(0);
    expect_seq("R3 aq", 2, 3'b010, 5'h02, 5'd7, 64'hA5A5);
  endtask

  task automatic t_rl;
    issue(1, 0, 1, 5'h03, 5'd9, 64'hBEEF);
    collect(1);
    expect_seq("R4 rl", 2, 3'b001, 5'h03, 5'd9, 64'hBEEF);
  endtask

  task automatic t_both;
    issue(1, 1, 1, 5'h04, 5'd31, 64'hFFFF_0000_FFFF_0001);
    collect(0);
    expect_seq("R5 aqrl", 3, 3'b101, 5'h04, 5'd31, 64'hFFFF_0000_FFFF_0001);
  endtask

  task automatic t_ops;
    for (int k = 0; k < 4; k++) begin
      logic [OP_W-1:0] op = OP_W'(k * 7 + 2);
      issue(1, 1, 1, op, 5'(k), 64'(k + 100));
      collect(0);
      expect_seq("R6 op independent", 3, 3'b101, op, 5'(k), 64'(k + 100));
    end
  endtask

  task automatic t_nonatomic;
    issue(0, 1, 1, 5'h1F, 5'd12, 64'h77);
    collect(0);
    expect_seq("R7 non-atomic", 1, 3'b000, 5'h1F, 5'd12, 64'h77);
  endtask

  task automatic t_stall;
    logic k0, l0;
    logic [DATA_W-1:0] d0;
    issue(1, 1, 1, 5'h05, 5'd4, 64'h5555);
    @(negedge clk); in_valid = 0; out_ready = 1; #1;
    chk("R9 first fence", out_kind, 1);
    @(posedge clk);
    @(negedge clk); out_ready = 0; #1;
    k0 = out_kind; l0 = out_last; d0 = out_data;
    chk("R9 mem presented", k0, 0);
    chk("R8 ready low while stalled", in_ready, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R9 valid held", out_valid, 1);
      chk("R9 kind held", out_kind, k0);
      chk("R9 last held", out_last, l0);
      chk("R9 data held", out_data, d0);
    end
    collect(0);
    expect_seq("R9 after stall", 2, 3'b010, 5'h05, 5'd4, 64'h5555);
  endtask

  task automatic t_b2b;
    issue(1, 1, 0, 5'h06, 5'd1, 64'h10);
    @(negedge clk); in_valid = 0; out_ready = 1; #1;
    chk("R11 first mem", out_kind, 0);
    @(posedge clk);
    @(negedge clk);
    present(1, 0, 0, 5'h07, 5'd2, 64'h20);
    #1;
    chk("R11 fence last", out_kind & out_last, 1);
    chk("R11 ready on last", in_ready, 1);
    @(posedge clk);
    @(negedge clk); in_valid = 0; out_ready = 1; #1;
    chk("R11 no bubble", out_valid, 1);
    chk("R11 next op", out_op, 5'h07);
    chk("R11 next last", out_last, 1);
    @(posedge clk);
    @(negedge clk); out_ready = 0; #1;
    chk("R11 idle after", out_valid, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    t_plain();
    t_aq();
    t_rl();
    t_both();
    t_ops();
    t_nonatomic();
    t_stall();
    t_b2b();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule